// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two signed operands and adds the product into a 64-bit accumulator. The accumulator is held as two 32-bit halves: the high half `acc_hi_o` and the low half `acc_lo_o`. There are two operation kinds. A long operation multiplies the full 32-bit operands. A word operation multiplies only their low 16 bits. A saturation enable, sampled with each operation, decides whether the sum wraps or is clipped. The two kinds clip differently. Long operations clip the whole accumulator to a signed 48-bit range. Word operations clip only the low half to a signed 32-bit range and report an overflow by writing 1 into the high half.

The surrounding datapath pulses `start_i` with the operands and controls. It reads the accumulator halves directly. It can clear both halves or load either half at any time. Start, done, clear and load are plain control pins with no back-pressure. Each accepted operation takes a fixed two cycles. While the unit is busy, a new start is not queued: it is dropped.

Top module: `mac_sat_unit`

## Requirements
- R1: Long operation (`op_word_i`=0) with saturation off: the signed 64-bit product of the two 32-bit signed operands is added to `{acc_hi_o,acc_lo_o}`, and the sum wraps modulo 2^64.
- R2: Long operation with saturation on: a result above 2^47-1 becomes 2^47-1, and a result below -2^47 becomes -2^47.
- R3: Long operation with saturation on, when the 64-bit addition itself overflows: the result is -2^47 if the previous accumulator was negative, and 2^47-1 otherwise.
- R4: Word operation (`op_word_i`=1): only bits 15:0 of each operand are used, taken as signed values. Bits 31:16 have no effect.
- R5: Word operation with saturation off: the 32-bit product is sign-extended and added to the full 64-bit accumulator, wrapping modulo 2^64.
- R6: Word operation with saturation on: the product is added to `acc_lo_o` alone, and the high half plays no part in the sum. On a signed 32-bit overflow, `acc_lo_o` becomes 0x7FFFFFFF if the old low half was non-negative and 0x80000000 if it was negative, and `acc_hi_o` becomes 1.
- R7: Word operation with saturation on and no 32-bit overflow: `acc_hi_o` keeps its value.
- R8: Reset zeros both halves. A `clr_i` pulse zeros both halves on the next edge.
- R9: `ld_hi_i` writes `ld_data_i` into the high half and `ld_lo_i` writes it into the low half. Each strobe leaves the other half untouched.
- R10: A start accepted at a clock edge updates the accumulator at the following edge. `done_o` is high for exactly that one cycle, two cycles after start was raised. `busy_o` is high in the cycle between the two edges.
- R11: A `start_i` sampled while `busy_o` is high is ignored: there is no extra accumulation and no extra done pulse.
- R12: When `clr_i`, `ld_hi_i` or `ld_lo_i` is active in the cycle an operation completes, the completing result is dropped and the clear or load takes effect. `done_o` still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation with the current operands |
| op_word_i | input | 1 | 0 = long 32x32, 1 = word 16x16 |
| sat_en_i | input | 1 | Saturating arithmetic for this operation |
| opa_i | input | 32 | First signed operand |
| opb_i | input | 32 | Second signed operand |
| clr_i | input | 1 | Zero both accumulator halves |
| ld_hi_i | input | 1 | Write `ld_data_i` into the high half |
| ld_lo_i | input | 1 | Write `ld_data_i` into the low half |
| ld_data_i | input | 32 | Data for the load strobes |
| busy_o | output | 1 | Operation in flight; starts are dropped |
| done_o | output | 1 | One-cycle pulse when the accumulator is updated |
| acc_hi_o | output | 32 | Accumulator high half |
| acc_lo_o | output | 32 | Accumulator low half |

## Verification
The bench sweeps seven preloaded accumulator values against every pair of eight corner operands, in both operation kinds and both saturation settings. The accumulator values sit near the 48-bit limits, at the 64-bit extremes and near the 32-bit low-half limits. It compares each result with a sum computed at full precision and then clipped. A unit that clipped long sums at 32 or 64 bits, tested the 64-bit overflow without looking at the previous sign, or let the high half take part in word saturation would show wrong accumulators here. So would one that forgot to set the high half to 1 on a word overflow. Operands with junk in their upper 16 bits expose a word product that uses the full operand. Directed runs hold start across the busy cycle and clash a clear or a load with a completing operation. A design that queued starts, pulsed done twice, or let the completing result win would fail those runs.

// File: rtl/mac_sat_pkg.sv
package mac_sat_pkg;

  typedef enum logic {
    OP_LONG = 1'b0,
    OP_WORD = 1'b1
  } mac_op_e;

  typedef struct packed {
    mac_op_e op;
    logic    sat;
  } mac_ctl_t;

endpackage

// File: rtl/mac_mul_stage.sv
module mac_mul_stage
  import mac_sat_pkg::*;
#(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           accept_i,
  input  mac_ctl_t       ctl_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic           vld_o,
  output mac_ctl_t       ctl_o,
  output logic [2*W-1:0] prod_o
);
  localparam int PW  = 2 * W;
  localparam int HPW = 2 * HW;

  logic signed [PW-1:0]  prod_long;
  logic signed [HPW-1:0] prod_half;
  logic [PW-1:0]         prod_sel;

  assign prod_long = $signed(a_i) * $signed(b_i);
  assign prod_half = $signed(a_i[HW-1:0]) * $signed(b_i[HW-1:0]);

  always_comb begin
    if (ctl_i.op == OP_WORD) prod_sel = {{(PW-HPW){prod_half[HPW-1]}}, prod_half};
    else                     prod_sel = prod_long;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      ctl_o  <= '0;
      prod_o <= '0;
    end else begin
      vld_o <= accept_i;
      if (accept_i) begin
        ctl_o  <= ctl_i;
        prod_o <= prod_sel;
      end
    end
  end
endmodule

// File: rtl/mac_add_sat.sv
module mac_add_sat
  import mac_sat_pkg::*;
#(
  parameter int W     = 32,
  parameter int SAT_W = 48
) (
  input  logic           vld_i,
  input  mac_ctl_t       ctl_i,
  input  logic [W-1:0]   hi_i,
  input  logic [W-1:0]   lo_i,
  input  logic [2*W-1:0] prod_i,
  output logic [W-1:0]   hi_o,
  output logic [W-1:0]   lo_o
);
  localparam int AW = 2 * W;
  localparam logic [AW-1:0] SAT_MAX = {{(AW-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic [AW-1:0] SAT_MIN = ~SAT_MAX;
  localparam logic [W-1:0]  LO_MAX  = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0]  LO_MIN  = ~LO_MAX;

  logic [AW-1:0]       acc, sum, res;
  logic [AW-SAT_W:0]   top_bits;
  logic                full_ovf, fits;
  logic [W-1:0]        lo_sum;
  logic                lo_ovf;

  always_comb begin
    acc      = {hi_i, lo_i};
    sum      = acc + prod_i;
    full_ovf = (acc[AW-1] == prod_i[AW-1]) && (sum[AW-1] != acc[AW-1]);
    top_bits = sum[AW-1:SAT_W-1];
    fits     = (&top_bits) || !(|top_bits);
    lo_sum   = lo_i + prod_i[W-1:0];
    lo_ovf   = (lo_i[W-1] == prod_i[W-1]) && (lo_sum[W-1] != lo_i[W-1]);
    res      = sum;
    hi_o     = sum[AW-1:W];
    lo_o     = sum[W-1:0];
    if (ctl_i.sat) begin
      if (ctl_i.op == OP_LONG) begin
        if (full_ovf)  res = acc[AW-1] ? SAT_MIN : SAT_MAX;
        else if (!fits) res = sum[AW-1] ? SAT_MIN : SAT_MAX;
        hi_o = res[AW-1:W];
        lo_o = res[W-1:0];
      end else begin
        hi_o = hi_i;
        lo_o = lo_sum;
        if (lo_ovf) begin
          hi_o = W'(1);
          lo_o = lo_i[W-1] ? LO_MIN : LO_MAX;
        end
      end
    end
  end

  always_comb begin
    if (vld_i && ctl_i.sat && ctl_i.op == OP_LONG) begin
      AST_LONG_IN_RANGE: assert ($signed({hi_o, lo_o}) <= $signed(SAT_MAX) && $signed({hi_o, lo_o}) >= $signed(SAT_MIN)); // R2
    end
    if (vld_i && ctl_i.sat && ctl_i.op == OP_WORD) begin
      AST_WORD_HI_KEPT: assert (hi_o == hi_i || hi_o == W'(1)); // R7
    end
  end
endmodule

// File: rtl/mac_acc_regs.sv
module mac_acc_regs #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         ld_hi_i,
  input  logic         ld_lo_i,
  input  logic [W-1:0] ld_data_i,
  input  logic         commit_i,
  input  logic [W-1:0] nxt_hi_i,
  input  logic [W-1:0] nxt_lo_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_o <= '0;
      lo_o <= '0;
    end else if (clr_i) begin
      hi_o <= '0;
      lo_o <= '0;
    end else if (ld_hi_i || ld_lo_i) begin
      if (ld_hi_i) hi_o <= ld_data_i;
      if (ld_lo_i) lo_o <= ld_data_i;
    end else if (commit_i) begin
      hi_o <= nxt_hi_i;
      lo_o <= nxt_lo_i;
    end
  end

  AST_CLEAR_ZEROS: assert property (@(posedge clk_i) disable iff (!rst_ni) clr_i |=> (hi_o == '0 && lo_o == '0)); // R8
  AST_LOAD_HI: assert property (@(posedge clk_i) disable iff (!rst_ni) (ld_hi_i && !clr_i) |=> hi_o == $past(ld_data_i)); // R9
  AST_LOAD_LO_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni) (ld_lo_i && !ld_hi_i && !clr_i) |=> $stable(hi_o)); // R9
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
  import mac_sat_pkg::*;
#(
  parameter int W     = 32,
  parameter int HW    = 16,
  parameter int SAT_W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         op_word_i,
  input  logic         sat_en_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         clr_i,
  input  logic         ld_hi_i,
  input  logic         ld_lo_i,
  input  logic [W-1:0] ld_data_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] acc_hi_o,
  output logic [W-1:0] acc_lo_o
);
  logic           s1_vld, accept, done_q;
  mac_ctl_t       ctl_in, s1_ctl;
  logic [2*W-1:0] s1_prod;
  logic [W-1:0]   nxt_hi, nxt_lo;

  assign accept     = start_i && !s1_vld;
  assign ctl_in.op  = op_word_i ? OP_WORD : OP_LONG;
  assign ctl_in.sat = sat_en_i;

  mac_mul_stage #(.W(W), .HW(HW)) u_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .ctl_i(ctl_in),
    .a_i(opa_i), .b_i(opb_i), .vld_o(s1_vld), .ctl_o(s1_ctl), .prod_o(s1_prod)
  );

  mac_add_sat #(.W(W), .SAT_W(SAT_W)) u_add (
    .vld_i(s1_vld), .ctl_i(s1_ctl), .hi_i(acc_hi_o), .lo_i(acc_lo_o),
    .prod_i(s1_prod), .hi_o(nxt_hi), .lo_o(nxt_lo)
  );

  mac_acc_regs #(.W(W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .ld_hi_i(ld_hi_i),
    .ld_lo_i(ld_lo_i), .ld_data_i(ld_data_i), .commit_i(s1_vld),
    .nxt_hi_i(nxt_hi), .nxt_lo_i(nxt_lo), .hi_o(acc_hi_o), .lo_o(acc_lo_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= s1_vld;
  end

  assign busy_o = s1_vld;
  assign done_o = done_q;

  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni) accept |=> ##1 done_o); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o); // R10
  AST_BUSY_DROPS_START: assert property (@(posedge clk_i) disable iff (!rst_ni) (busy_o && start_i) |=> !busy_o); // R11
endmodule

// File: tb/mac_sat_unit_bench.sv
`timescale 1ns/1ps
module mac_sat_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, op_word = 1'b0, sat_en = 1'b0;
  logic [31:0] opa = '0, opb = '0, ld_data = '0;
  logic        clr = 1'b0, ld_hi = 1'b0, ld_lo = 1'b0;
  logic        busy, done;
  logic [31:0] acc_hi, acc_lo;
  int          n_cmp = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  mac_sat_unit u_mac_sat_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_word_i(op_word),
    .sat_en_i(sat_en), .opa_i(opa), .opb_i(opb), .clr_i(clr),
    .ld_hi_i(ld_hi), .ld_lo_i(ld_lo), .ld_data_i(ld_data),
    .busy_o(busy), .done_o(done), .acc_hi_o(acc_hi), .acc_lo_o(acc_lo)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: got cycle %0d expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(logic [63:0] acc, logic [31:0] a, logic [31:0] b,
                                        logic word, logic sat);
    logic signed [63:0] sa, sb, p;
    logic signed [65:0] exact;
    logic signed [32:0] e33;
    if (word) begin
      sa = {{48{a[15]}}, a[15:0]};
      sb = {{48{b[15]}}, b[15:0]};
    end else begin
      sa = {{32{a[31]}}, a};
      sb = {{32{b[31]}}, b};
    end
    p = sa * sb;
    if (!sat) return acc + p;
    if (!word) begin
      exact = $signed({{2{acc[63]}}, acc}) + $signed({{2{p[63]}}, p});
      if (exact > 66'sd140737488355327) return 64'h0000_7FFF_FFFF_FFFF;
      if (exact < -66'sd140737488355328) return 64'hFFFF_8000_0000_0000;
      return exact[63:0];
    end
    e33 = $signed({acc[31], acc[31:0]}) + $signed({p[31], p[31:0]});
    if (e33 > 33'sd2147483647) return {32'd1, 32'h7FFF_FFFF};
    if (e33 < -33'sd2147483648) return {32'd1, 32'h8000_0000};
    return {acc[63:32], e33[31:0]};
  endfunction

  task automatic load_acc(logic [63:0] v);
    @(negedge clk); ld_hi = 1'b1; ld_data = v[63:32];
    @(negedge clk); ld_hi = 1'b0; ld_lo = 1'b1; ld_data = v[31:0];
    @(negedge clk); ld_lo = 1'b0;
  endtask

  task automatic run_op(logic [31:0] a, logic [31:0] b, logic word, logic sat);
    @(negedge clk); start = 1'b1; opa = a; opb = b; op_word = word; sat_en = sat;
    @(negedge clk); start = 1'b0;
    chk("R10 busy/done mid", {62'd0, busy, done}, 64'd2);
    @(negedge clk);
    chk("R10 done pulse", {63'd0, done}, 64'd1);
  endtask

  logic [63:0] accs [7];
  logic [31:0] opv  [8];

  initial begin
    accs[0] = 64'h0;                   accs[1] = 64'h0000_7FFF_FFFF_0000;
    accs[2] = 64'hFFFF_8000_0001_0000; accs[3] = 64'h7FFF_FFFF_FFFF_FFFF;
    accs[4] = 64'h8000_0000_0000_0000; accs[5] = 64'h1234_5678_7FFF_FFF0;
    accs[6] = 64'h0000_ABCD_8000_0010;
    opv[0] = 32'h0;        opv[1] = 32'h1;        opv[2] = 32'hFFFF_FFFF;
    opv[3] = 32'h7FFF_FFFF; opv[4] = 32'h8000_0000; opv[5] = 32'h0000_7FFF;
    opv[6] = 32'hFFFF_8000; opv[7] = 32'h1234_8000;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset state", {acc_hi, acc_lo}, 64'h0);
    chk("R10 idle after reset", {62'd0, busy, done}, 64'd0);

    // R9: each load strobe writes only its own half
    load_acc(64'h0123_4567_89AB_CDEF);
    chk("R9 load both", {acc_hi, acc_lo}, 64'h0123_4567_89AB_CDEF);
    @(negedge clk); ld_lo = 1'b1; ld_data = 32'h5555_AAAA;
    @(negedge clk); ld_lo = 1'b0;
    chk("R9 load lo only", {acc_hi, acc_lo}, 64'h0123_4567_5555_AAAA);

    // R8: clear
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R8 clear", {acc_hi, acc_lo}, 64'h0);

    // R8: reset in mid-run
    load_acc(64'hDEAD_BEEF_CAFE_F00D);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R8 reset zeros", {acc_hi, acc_lo}, 64'h0);

    // R4: upper operand bits ignored in word mode
    load_acc(64'h0);
    run_op(32'hABCD_0003, 32'h1234_FFFE, 1'b1, 1'b0);
    chk("R4 word upper ignored", {acc_hi, acc_lo}, 64'hFFFF_FFFF_FFFF_FFFA);

    // R3: 64-bit overflow picks the limit by the old sign
    load_acc(64'h7FFF_FFFF_FFFF_FFFF);
    run_op(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1);
    chk("R3 pos overflow", {acc_hi, acc_lo}, 64'h0000_7FFF_FFFF_FFFF);
    load_acc(64'h8000_0000_0000_0000);
    run_op(32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 1'b1);
    chk("R3 neg overflow", {acc_hi, acc_lo}, 64'hFFFF_8000_0000_0000);

    // R7: no overflow keeps the high half
    load_acc(64'h9999_0000_0000_0010);
    run_op(32'h0000_0002, 32'h0000_0003, 1'b1, 1'b1);
    chk("R7 hi kept", {acc_hi, acc_lo}, 64'h9999_0000_0000_0016);

    // R11: start held across busy cycle is dropped
    load_acc(64'h0);
    @(negedge clk); start = 1'b1; opa = 32'd3; opb = 32'd5; op_word = 1'b0; sat_en = 1'b0;
    @(negedge clk);
    @(negedge clk); start = 1'b0;
    chk("R11 first result", {acc_hi, acc_lo}, 64'd15);
    @(negedge clk);
    chk("R11 no second done", {63'd0, done}, 64'd0);
    @(negedge clk);
    chk("R11 no second accumulation", {acc_hi, acc_lo}, 64'd15);
    chk("R11 idle", {62'd0, busy, done}, 64'd0);

    // R12: clear and load beat a completing result
    load_acc(64'h0);
    @(negedge clk); start = 1'b1; opa = 32'd2; opb = 32'd3;
    @(negedge clk); start = 1'b0; clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R12 clear wins", {acc_hi, acc_lo}, 64'h0);
    chk("R12 done still pulses", {63'd0, done}, 64'd1);
    @(negedge clk); start = 1'b1; opa = 32'd2; opb = 32'd3;
    @(negedge clk); start = 1'b0; ld_hi = 1'b1; ld_data = 32'h0000_0077;
    @(negedge clk); ld_hi = 1'b0;
    chk("R12 load wins", {acc_hi, acc_lo}, 64'h0000_0077_0000_0000);

    // Sweep: R1 R2 R5 R6 against the arithmetic model
    for (int ai = 0; ai < 7; ai++)
      for (int xi = 0; xi < 8; xi++)
        for (int yi = 0; yi < 8; yi++)
          for (int m = 0; m < 4; m++) begin
            logic wd, st;
            logic [63:0] exp;
            string tg;
            wd = m[1]; st = m[0];
            load_acc(accs[ai]);
            run_op(opv[xi], opv[yi], wd, st);
            exp = model(accs[ai], opv[xi], opv[yi], wd, st);
            if (!wd) tg = st ? "R2/R3 long sat" : "R1 long wrap";
            else     tg = st ? "R6/R7 word sat" : "R5 word wrap";
            chk(tg, {acc_hi, acc_lo}, exp);
          end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule